// File: doc/BRIEF.md
# Inverting PWM Timer Channel

This block is one timer channel that produces a pulse-width-modulated pin. A 24-bit value, made of an 8-bit prescale extension above a 16-bit load value, sets the period. A 24-bit match value, built the same way from an 8-bit match extension above a 16-bit match word, sets the point in the period where the output goes low. The counter steps down by one on every clock and reloads when it reaches zero. Before any inversion, the waveform is high from the reload until the count meets the match value, and low from that point until the next reload.

Software sets the channel up through a small write-only register port. It selects split 16-bit operation in a configuration register, selects PWM operation in a mode register, and then starts the channel with the enable bit of a control register. The control register also selects output inversion and the edge that raises an interrupt. The interrupt is a one-cycle pulse, and it is gated by an enable bit in the mode register. The period may be retuned while the channel runs. Every other setting is frozen while the channel is enabled.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset, `pwm_out` and `irq` are 0 and every register holds 0.
- R2: The channel runs only when all three of these hold: the configuration register's low 4 bits equal 4, mode bits [3:0] equal 4'b1010 (bits [1:0] mode = 2, bit 2 capture = 0, bit 3 alternate-select = 1), and control bit 0 (enable) is 1. Otherwise `pwm_out` and `irq` stay 0.
- R3: The period value V is {prescale[7:0], load[15:0]}, at addresses 4 and 3. While running, the counter starts at V, decrements once per clock, and reloads V in the cycle after it reads zero, so one period lasts V+1 cycles.
- R4: The match value M is {match-extension[7:0] at address 6, match[15:0] at address 5}. The non-inverted output is high for V-M cycles after each reload and low for the M+1 cycles in which the count runs from M down to 0.
- R5: When M >= V, the non-inverted output stays high for the whole run.
- R6: Control bit 1 inverts the level on `pwm_out` while the channel runs.
- R7: Mode bit 4 enables the interrupt. Control bits [3:2] select the edge of the non-inverted waveform that raises it: 00 rising, 01 falling, 11 both, 10 none. `irq` is high for one cycle, in the same cycle that `pwm_out` shows the new level.
- R8: With inversion on, the selected edge appears reversed on the pin. For example, setting 00 pulses `irq` when `pwm_out` falls.
- R9: Writes to load (address 3) and prescale (address 4) are accepted at any time. The period in progress finishes with the old value, and the next reload uses the new value.
- R10: While enable is 1, writes to configuration (0), mode (1), match (5) and match extension (6) are ignored. A control write (2) changes only the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 cfg, 1 mode, 2 ctrl, 3 load, 4 prescale, 5 match, 6 match extension) |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 1 | PWM pin |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The channel is driven with a short period (V=9, M=3) to separate the high and low lengths and the reload point. It is also driven with a period that uses both extension bytes, which catches a prescale or match extension that is wired wrong. Further runs use a match at or above the load value, inverted output with each edge selection, and a load write in the middle of a period, which separates a reload at the next period from an immediate restart. Writes to locked registers while the channel is enabled, and configuration or mode codes off by one field, show whether the locks and the run qualification hold.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  localparam logic [2:0] ADR_CFG  = 3'd0;
  localparam logic [2:0] ADR_MODE = 3'd1;
  localparam logic [2:0] ADR_CTRL = 3'd2;
  localparam logic [2:0] ADR_LOAD = 3'd3;
  localparam logic [2:0] ADR_PRE  = 3'd4;
  localparam logic [2:0] ADR_MAT  = 3'd5;
  localparam logic [2:0] ADR_MPRE = 3'd6;

  localparam logic [3:0] CFG_SPLIT16 = 4'd4;
  localparam logic [3:0] MODE_PWM    = 4'b1010;

  typedef enum logic [1:0] {
    EV_RISE = 2'b00,
    EV_FALL = 2'b01,
    EV_NONE = 2'b10,
    EV_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    edge_sel_e evt;
    logic      inv;
    logic      en;
  } ctrl_t;

  function automatic logic edge_fires(edge_sel_e sel, logic rise, logic fall);
    case (sel)
      EV_RISE: return rise;
      EV_FALL: return fall;
      EV_BOTH: return rise | fall;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic setup_valid(logic [3:0] cfg, logic [3:0] mode_bits);
    return (cfg == CFG_SPLIT16) && (mode_bits == MODE_PWM);
  endfunction

endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int DATA_W = 16,
  localparam int FULL_W = CNT_W + PRE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              run,
  output logic              inv,
  output logic              ie,
  output edge_sel_e         evt,
  output logic [FULL_W-1:0] ival,
  output logic [FULL_W-1:0] mval
);

  logic [3:0]       cfg_q;
  logic [4:0]       mode_q;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] mat_q;
  logic [PRE_W-1:0] mpre_q;

  logic wr_locked;
  assign wr_locked = ctrl_q.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mode_q <= '0;
      ctrl_q <= '{evt: EV_RISE, inv: 1'b0, en: 1'b0};
      load_q <= '0;
      pre_q  <= '0;
      mat_q  <= '0;
      mpre_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CFG:  if (!wr_locked) cfg_q  <= wr_data[3:0];
        ADR_MODE: if (!wr_locked) mode_q <= wr_data[4:0];
        ADR_CTRL: begin
          if (!wr_locked) begin
            ctrl_q.inv <= wr_data[1];
            ctrl_q.evt <= edge_sel_e'(wr_data[3:2]);
          end
          ctrl_q.en <= wr_data[0];
        end
        ADR_LOAD: load_q <= wr_data[CNT_W-1:0];
        ADR_PRE:  pre_q  <= wr_data[PRE_W-1:0];
        ADR_MAT:  if (!wr_locked) mat_q  <= wr_data[CNT_W-1:0];
        ADR_MPRE: if (!wr_locked) mpre_q <= wr_data[PRE_W-1:0];
        default: ;
      endcase
    end
  end

  assign run  = ctrl_q.en && setup_valid(cfg_q, mode_q[3:0]);
  assign inv  = ctrl_q.inv;
  assign ie   = mode_q[4];
  assign evt  = ctrl_q.evt;
  assign ival = {pre_q, load_q};
  assign mval = {mpre_q, mat_q};

  assert_lock_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.en |=> $stable(mval));
  assert_lock_setup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.en |=> ($stable(cfg_q) && $stable(mode_q) && $stable(inv) && $stable(evt)));

endmodule

// File: rtl/pwm_timer_counter.sv
module pwm_timer_counter #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8,
  localparam int FULL_W = CNT_W + PRE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [FULL_W-1:0] ival,
  input  logic [FULL_W-1:0] mval,
  output logic              raw,
  output logic              rise_evt,
  output logic              fall_evt
);

  function automatic logic [FULL_W-1:0] step_down(logic [FULL_W-1:0] c);
    return c - FULL_W'(1);
  endfunction

  function automatic logic hits_match(logic [FULL_W-1:0] c, logic [FULL_W-1:0] m);
    return (c != '0) && (step_down(c) == m);
  endfunction

  logic [FULL_W-1:0] cnt_q, cnt_d;
  logic              raw_q, raw_d;
  logic              at_zero, clr_hit;

  always_comb begin
    at_zero = (cnt_q == '0);
    clr_hit = hits_match(cnt_q, mval);
    if (!run || at_zero) begin
      cnt_d = ival;
      raw_d = 1'b1;
    end else begin
      cnt_d = step_down(cnt_q);
      raw_d = clr_hit ? 1'b0 : raw_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      raw_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      raw_q <= raw_d;
    end
  end

  assign raw      = raw_q;
  assign rise_evt = run && !raw_q && raw_d;
  assign fall_evt = run && raw_q && !raw_d;

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q == '0) |=> (cnt_q == $past(ival)));
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - FULL_W'(1)));
  assert_fall_at_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(raw_q) |-> (cnt_q == mval));
  assert_rise_after_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> ($past(cnt_q) == '0 || !$past(run)));

endmodule

// File: rtl/pwm_timer_irq.sv
module pwm_timer_irq
  import pwm_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      ie,
  input  edge_sel_e evt,
  input  logic      rise_evt,
  input  logic      fall_evt,
  output logic      irq
);

  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= run && ie && edge_fires(evt, rise_evt, fall_evt);
  end

  assign irq = irq_q;

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(ie));
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !irq_q);

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int DATA_W = 16,
  localparam int FULL_W = CNT_W + PRE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_out,
  output logic              irq
);

  logic              run, inv, ie;
  edge_sel_e         evt;
  logic [FULL_W-1:0] ival, mval;
  logic              raw, rise_evt, fall_evt;

  pwm_timer_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .inv(inv), .ie(ie), .evt(evt), .ival(ival), .mval(mval)
  );

  pwm_timer_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .ival(ival), .mval(mval),
    .raw(raw), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  pwm_timer_irq u_irq (
    .clk(clk), .rst_n(rst_n), .run(run), .ie(ie), .evt(evt),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .irq(irq)
  );

  assign pwm_out = run ? (raw ^ inv) : 1'b0;

  assert_irq_on_pin_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && run) |-> (pwm_out != $past(pwm_out)));
  assert_const_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && mval >= ival && $stable(ival) && raw && !inv) |=> (pwm_out || !run));

endmodule

// File: tb/pwm_timer_chan_tb_top.sv
module pwm_timer_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_out, irq;

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  bit chk_on = 1'b0;
  bit finished = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  pwm_timer_chan dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .irq(irq)
  );

  // behavioural reference state
  int       m_cnt;
  bit       m_raw, m_irq, m_en, m_inv;
  bit [3:0] m_cfg;
  bit [4:0] m_mode;
  bit [1:0] m_evt;
  int       m_load, m_pre, m_mat, m_mpre;
  int       iv, mv;
  bit       mrun, r0, rise, fall;

  function automatic bit model_runs();
    return m_en && m_cfg == 4 && m_mode[3:0] == 4'b1010;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_raw = 1; m_irq = 0; m_en = 0; m_inv = 0; m_cfg = 0;
      m_mode = 0; m_evt = 0; m_load = 0; m_pre = 0; m_mat = 0; m_mpre = 0;
    end else begin
      mrun = model_runs();
      iv = m_pre * 65536 + m_load;
      mv = m_mpre * 65536 + m_mat;
      r0 = m_raw;
      if (!mrun || m_cnt == 0) begin
        m_cnt = iv; m_raw = 1;
      end else begin
        m_cnt = m_cnt - 1;
        if (m_cnt == mv) m_raw = 0;
      end
      rise = mrun && !r0 && m_raw;
      fall = mrun && r0 && !m_raw;
      m_irq = mrun && m_mode[4] &&
              ((m_evt == 2'b00 && rise) || (m_evt == 2'b01 && fall) ||
               (m_evt == 2'b11 && (rise || fall)));
      if (wr_en) begin
        case (wr_addr)
          3'd0: if (!m_en) m_cfg = wr_data[3:0];
          3'd1: if (!m_en) m_mode = wr_data[4:0];
          3'd2: begin
            if (!m_en) begin m_inv = wr_data[1]; m_evt = wr_data[3:2]; end
            m_en = wr_data[0];
          end
          3'd3: m_load = int'(wr_data);
          3'd4: m_pre = int'(wr_data[7:0]);
          3'd5: if (!m_en) m_mat = int'(wr_data);
          3'd6: if (!m_en) m_mpre = int'(wr_data[7:0]);
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      check(cur_req, int'(pwm_out), (model_runs() ? int'(m_raw ^ m_inv) : 0), "pwm_out vs model");
      check(cur_req, int'(irq), int'(m_irq), "irq vs model");
    end
  end

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_rise(output int t);
    bit pv;
    @(negedge clk);
    pv = pwm_out;
    forever begin
      @(negedge clk);
      if (!pv && pwm_out) break;
      pv = pwm_out;
    end
    t = cyc;
  endtask

  task automatic high_len(output int h);
    int t;
    wait_rise(t);
    h = 0;
    while (pwm_out) begin h++; @(negedge clk); end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int t0, t1, t2, h, cnt;
    bit pv;
    idle(3);
    // R1: reset state
    check("R1", int'(pwm_out), 0, "pwm_out in reset");
    check("R1", int'(irq), 0, "irq in reset");
    @(posedge clk); #1; rst_n = 1'b1;
    chk_on = 1'b1;
    idle(2);
    check("R1", int'(pwm_out), 0, "pwm_out after reset");

    // R2: wrong configuration code keeps the channel idle
    cur_req = "R2";
    wr(3'd3, 16'd9); wr(3'd5, 16'd3);
    wr(3'd1, 16'h001A); wr(3'd0, 16'd0); wr(3'd2, 16'h000D);
    cnt = 0;
    for (int i = 0; i < 25; i++) begin @(negedge clk); cnt += int'(pwm_out) + int'(irq); end
    check("R2", cnt, 0, "activity with cfg=0");
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'd4); wr(3'd1, 16'h001E); wr(3'd2, 16'h000D);
    cnt = 0;
    for (int i = 0; i < 25; i++) begin @(negedge clk); cnt += int'(pwm_out) + int'(irq); end
    check("R2", cnt, 0, "activity with capture bit set");
    wr(3'd2, 16'h0000);

    // R3 R4 R7: V=9 M=3, both edges
    cur_req = "R4";
    wr(3'd1, 16'h001A); wr(3'd2, 16'h000D);
    wait_rise(t0); wait_rise(t1);
    check("R3", t1 - t0, 10, "period V+1");
    high_len(h);
    check("R4", h, 6, "high length V-M");
    cur_req = "R7";
    wait_rise(t0);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); cnt += int'(irq); end
    check("R7", cnt, 6, "both-edge irq count over 3 periods");
    wr(3'd2, 16'h0000);
    wr(3'd2, 16'h0009);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); cnt += int'(irq); end
    check("R7", cnt, 0, "irq with edge select none");
    wr(3'd2, 16'h0000);

    // R6 R8: inverted, rising select fires on pin falling
    cur_req = "R8";
    wr(3'd2, 16'h0003);
    cnt = 0;
    pv = pwm_out;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irq) begin
        cnt++;
        check("R8", int'({pv, pwm_out}), 2, "pin falls with rising-select irq");
      end
      pv = pwm_out;
    end
    check("R8", int'(cnt >= 3), 1, "irq seen under inversion");
    cur_req = "R6";
    high_len(h);
    check("R6", h, 4, "inverted high length M+1");

    // R10: locked writes ignored while enabled
    cur_req = "R10";
    wr(3'd5, 16'd0); wr(3'd0, 16'd0); wr(3'd1, 16'h0000); wr(3'd2, 16'h0001);
    wait_rise(t0); wait_rise(t1);
    check("R10", t1 - t0, 10, "period after locked writes");
    high_len(h);
    check("R10", h, 4, "inversion kept after ctrl write");
    wr(3'd2, 16'h0000);

    // R5: match above load
    cur_req = "R5";
    wr(3'd5, 16'd20); wr(3'd2, 16'h000D);
    idle(2);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); cnt += int'(pwm_out); end
    check("R5", cnt, 40, "constant high when M>=V");
    wr(3'd2, 16'h0000);

    // R9: load change mid-period
    cur_req = "R9";
    wr(3'd5, 16'd3); wr(3'd2, 16'h000D);
    wait_rise(t0);
    wr(3'd3, 16'd4);
    wait_rise(t1); wait_rise(t2);
    check("R9", t1 - t0, 10, "current period keeps old load");
    check("R9", t2 - t1, 5, "next period uses new load");
    wr(3'd2, 16'h0000);

    // R3 R4: extension bytes, V=65540 M=65536
    cur_req = "R3";
    wr(3'd4, 16'd1); wr(3'd6, 16'd1); wr(3'd5, 16'd0); wr(3'd2, 16'h000D);
    wait_rise(t0); wait_rise(t1);
    check("R3", t1 - t0, 65541, "period with prescale extension");
    wr(3'd2, 16'h0000);
    idle(5);
    finish_run();
  end

endmodule